// File: doc/BRIEF.md
# Dual-Mode Serial Byte Delivery Interface

This block hands 8-bit words from an upstream FSK demodulator to a host over three lines: a serial data line, a data clock and an active-low data-ready line. The upstream side presents each word as a one-cycle strobe with the byte alongside. A mode input chooses who paces the transfer.

With the mode input low, the block paces the transfer itself. It drives the data clock and puts one bit per bit period on the data line, least significant bit first. Once the eighth clock pulse is done it pulls data-ready low for a fixed time to mark the end of the word. The bit period is a parameter, set to the system clock rate divided by 1200 for a 1200 baud stream. With the mode input high, the host paces the transfer. The block holds the byte and pulls data-ready low to say it is waiting. The host then clocks the bits out with its own clock. The block synchronises that clock into the system domain and detects its rising edges there; it never uses it as a clock.

A power-down input puts the whole interface in its idle state. A one-cycle overrun pulse reports every byte that is lost.

Top module: `fsk_host_link`

## Requirements
- R1: With mode_sel_i = 0 the data clock is driven by the block (dclk_oe_o = 1). With mode_sel_i = 1, dclk_oe_o = 0, dclk_o = 0, and no self-paced transfer is in progress.
- R2: In mode 0 a strobe on an idle interface starts a word. Each of the 8 bits goes out least significant bit first and lasts BIT_CYCLES cycles. DATA holds the bit for its whole period, and DCLK is low for the first BIT_CYCLES/2 cycles and high for the rest, so sampling DATA at the 8 DCLK rising edges yields the byte.
- R3: In mode 0, dr_n_o goes low 8*BIT_CYCLES cycles after the clock edge that accepts the strobe, directly after the eighth DCLK high phase. It stays low for DR_CYCLES cycles. DATA idles high whenever no bit is being sent.
- R4: In mode 0, a strobe that arrives while a word or its ready mark is in progress is dropped and pulses overrun_o for one cycle. The word in progress completes unchanged.
- R5: In mode 1, a strobe loads the byte. From the next cycle, dr_n_o is low and DATA shows bit 0.
- R6: In mode 1, the k-th synchronised rising edge of dclk_i (k = 1..7) moves DATA to bit k. The eighth edge returns dr_n_o high and DATA to 1.
- R7: In mode 1, a strobe while a word is pending (unread or partly read) replaces the byte and pulses overrun_o. dr_n_o goes high for exactly one cycle and then low again, and reading restarts at bit 0 of the new byte.
- R8: In mode 1, dclk_i rising edges while no word is pending have no effect. dr_n_o stays high, DATA stays 1, and the next word still starts at bit 0.
- R9: While pwr_down_i is high, dr_n_o = 1, data_o = 1 and dclk_o = 0. Strobes are ignored, and a transfer in progress is abandoned without a later ready mark.
- R10: After reset, dr_n_o = 1, data_o = 1, dclk_o = 0 and overrun_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 1 | 0: block paces transfers, 1: host paces transfers |
| pwr_down_i | input | 1 | Forces the interface idle |
| byte_vld_i | input | 1 | One-cycle strobe: byte_i carries a new word |
| byte_i | input | 8 | Demodulated word |
| dclk_i | input | 1 | Host data clock (mode 1) |
| dclk_o | output | 1 | Block data clock (mode 0) |
| dclk_oe_o | output | 1 | Data clock direction: 1 when the block drives it |
| data_o | output | 1 | Serial data, least significant bit first |
| dr_n_o | output | 1 | Data ready, active low |
| overrun_o | output | 1 | One-cycle pulse when a word is lost |

## Verification
Some properties are checked on every cycle. DATA must not change during a DCLK high phase. The ready mark may only fall right after a high clock phase. Overrun may only pulse when a word was already in flight. Data in host mode holds between host edges. A rise of data-ready must have a cause. Power-down and host mode must leave the self-paced engine empty. Other behaviour can only be shown by the bench's scenarios, which act as the host: the bit order, the exact 8*BIT_CYCLES latency, the width of the ready mark, the one-cycle ready gap on an overwrite, edges ignored while idle, and the absence of a ready mark after power-down.

// File: rtl/fhl_pkg.sv
package fhl_pkg;

  typedef enum logic [1:0] {
    PUSH_IDLE  = 2'd0,
    PUSH_SHIFT = 2'd1,
    PUSH_MARK  = 2'd2
  } push_state_e;

  // Length of the low phase of a self-paced clock period.
  function automatic int unsigned low_phase(input int unsigned bit_cycles);
    return bit_cycles / 2;
  endfunction

  // Clock level for a given position inside a bit period.
  function automatic logic clk_level(input int unsigned pos, input int unsigned bit_cycles);
    return (pos >= low_phase(bit_cycles)) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/fhl_edge_sync.sv
module fhl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/fhl_push_tx.sv
module fhl_push_tx
  import fhl_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int BIT_CYCLES = 16,
  parameter int DR_CYCLES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              data_o,
  output logic              dclk_o,
  output logic              dr_n_o,
  output logic              busy_o,
  output logic              drop_o
);
  localparam int CNT_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int MK_W  = (DR_CYCLES > 1) ? $clog2(DR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);
  localparam logic [MK_W-1:0]  MK_LAST  = MK_W'(DR_CYCLES - 1);

  push_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [MK_W-1:0]   mk_q;
  logic [WORD_W-1:0] sh_q;
  logic              drop_q;

  // named internal events
  logic bit_end;
  logic word_end;
  assign bit_end  = (state_q == PUSH_SHIFT) && (cnt_q == CNT_LAST);
  assign word_end = bit_end && (idx_q == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PUSH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      mk_q    <= '0;
      sh_q    <= '1;
      drop_q  <= 1'b0;
    end else begin
      drop_q <= en_i && load_i && (state_q != PUSH_IDLE);
      if (!en_i) begin
        state_q <= PUSH_IDLE;
      end else begin
        case (state_q)
          PUSH_IDLE: begin
            if (load_i) begin
              state_q <= PUSH_SHIFT;
              sh_q    <= word_i;
              cnt_q   <= '0;
              idx_q   <= '0;
            end
          end
          PUSH_SHIFT: begin
            if (bit_end) begin
              cnt_q <= '0;
              sh_q  <= sh_q >> 1;
              if (word_end) begin
                state_q <= PUSH_MARK;
                mk_q    <= '0;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PUSH_MARK: begin
            if (mk_q == MK_LAST) state_q <= PUSH_IDLE;
            else                 mk_q    <= mk_q + 1'b1;
          end
          default: state_q <= PUSH_IDLE;
        endcase
      end
    end
  end

  assign data_o = (state_q == PUSH_SHIFT) ? sh_q[0] : 1'b1;
  assign dclk_o = (state_q == PUSH_SHIFT) && clk_level(int'(cnt_q), BIT_CYCLES);
  assign dr_n_o = (state_q != PUSH_MARK);
  assign busy_o = (state_q != PUSH_IDLE);
  assign drop_o = drop_q;

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_o && $past(dclk_o)) |-> $stable(data_o)); // R2

  AST_MARK_AFTER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dr_n_o) |-> $past(dclk_o)); // R3

  AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> $past(busy_o)); // R4

endmodule

// File: rtl/fhl_pull_tx.sv
module fhl_pull_tx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rise_i,
  output logic              data_o,
  output logic              dr_n_o,
  output logic              busy_o,
  output logic              ovr_o
);
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  logic              pend_q;
  logic              rearm_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] sh_q;
  logic              ovr_q;

  // named internal events
  logic take_edge;
  logic overwrite;
  assign take_edge = pend_q && rise_i;
  assign overwrite = load_i && (pend_q || rearm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      rearm_q <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '1;
      ovr_q   <= 1'b0;
    end else begin
      ovr_q <= en_i && overwrite;
      if (!en_i) begin
        pend_q  <= 1'b0;
        rearm_q <= 1'b0;
      end else if (load_i) begin
        sh_q    <= word_i;
        idx_q   <= '0;
        pend_q  <= !overwrite;
        rearm_q <= overwrite;
      end else if (rearm_q) begin
        rearm_q <= 1'b0;
        pend_q  <= 1'b1;
      end else if (take_edge) begin
        if (idx_q == IDX_LAST) begin
          pend_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= sh_q >> 1;
        end
      end
    end
  end

  assign data_o = (pend_q || rearm_q) ? sh_q[0] : 1'b1;
  assign dr_n_o = !pend_q;
  assign busy_o = pend_q || rearm_q;
  assign ovr_o  = ovr_q;

  AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pend_q && !rise_i && !load_i) |=> $stable(data_o)); // R6

  AST_READY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dr_n_o) |-> ($past(rise_i) || $past(load_i) || $past(!en_i))); // R6

  AST_OVR_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> $past(busy_o)); // R7

  AST_REARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && rearm_q && !load_i) |=> !dr_n_o); // R7

endmodule

// File: rtl/fsk_host_link.sv
module fsk_host_link
  import fhl_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int BIT_CYCLES  = 16,
  parameter int DR_CYCLES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel_i,
  input  logic              pwr_down_i,
  input  logic              byte_vld_i,
  input  logic [WORD_W-1:0] byte_i,
  input  logic              dclk_i,
  output logic              dclk_o,
  output logic              dclk_oe_o,
  output logic              data_o,
  output logic              dr_n_o,
  output logic              overrun_o
);
  logic push_en, pull_en;
  logic push_data, push_dclk, push_dr_n, push_busy, push_drop;
  logic pull_data, pull_dr_n, pull_busy, pull_ovr;
  logic host_rise;

  assign push_en = !pwr_down_i && !mode_sel_i;
  assign pull_en = !pwr_down_i &&  mode_sel_i;

  fhl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (dclk_i),
    .rise_o  (host_rise)
  );

  fhl_push_tx #(
    .WORD_W     (WORD_W),
    .BIT_CYCLES (BIT_CYCLES),
    .DR_CYCLES  (DR_CYCLES)
  ) u_push (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (push_en),
    .load_i (byte_vld_i),
    .word_i (byte_i),
    .data_o (push_data),
    .dclk_o (push_dclk),
    .dr_n_o (push_dr_n),
    .busy_o (push_busy),
    .drop_o (push_drop)
  );

  fhl_pull_tx #(.WORD_W(WORD_W)) u_pull (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (pull_en),
    .load_i (byte_vld_i),
    .word_i (byte_i),
    .rise_i (host_rise),
    .data_o (pull_data),
    .dr_n_o (pull_dr_n),
    .busy_o (pull_busy),
    .ovr_o  (pull_ovr)
  );

  assign dclk_oe_o = !mode_sel_i;
  assign dclk_o    = push_en && push_dclk;
  assign data_o    = pwr_down_i ? 1'b1 : (mode_sel_i ? pull_data : push_data);
  assign dr_n_o    = pwr_down_i ? 1'b1 : (mode_sel_i ? pull_dr_n : push_dr_n);
  assign overrun_o = push_drop || pull_ovr;

  AST_HOST_MODE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_sel_i) && mode_sel_i) |-> !push_busy); // R1

  AST_PWDN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_down_i) && pwr_down_i) |-> (!push_busy && !pull_busy)); // R9

  AST_ONE_LOSS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_drop, pull_ovr})); // R4

endmodule

// File: tb/fsk_host_link_bench.sv
module fsk_host_link_bench;
  localparam int W  = 8;
  localparam int B  = 16;
  localparam int D  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0, pwr_down = 1'b0, vld = 1'b0, dclk_in = 1'b0;
  logic [W-1:0] din = '0;
  logic dclk_out, dclk_oe, data, dr_n, ovr;

  int checks = 0, errors = 0;
  int ovr_seen = 0, dr_falls = 0;
  logic dr_prev = 1'b1;
  bit done = 0;

  always #5 clk = ~clk;

  fsk_host_link #(.WORD_W(W), .BIT_CYCLES(B), .DR_CYCLES(D), .SYNC_STAGES(2)) u_fsk_host_link (
    .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel), .pwr_down_i(pwr_down),
    .byte_vld_i(vld), .byte_i(din), .dclk_i(dclk_in), .dclk_o(dclk_out),
    .dclk_oe_o(dclk_oe), .data_o(data), .dr_n_o(dr_n), .overrun_o(ovr));

  always @(posedge clk) begin
    if (ovr) ovr_seen++;
    if (dr_prev && !dr_n) dr_falls++;
    dr_prev <= dr_n;
  end

  function automatic int exp_latency(input int bit_cycles, input int word_w);
    return bit_cycles * word_w;
  endfunction

  function automatic logic exp_bit(input logic [W-1:0] b, input int k);
    logic [W-1:0] t;
    t = b;
    for (int i = 0; i < k; i++) t = {1'b0, t[W-1:1]};
    return t[0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [W-1:0] b);
    din = b; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  // Mode 0 receiver: strobe, collect bits at DCLK rises, measure latency and mark width
  task automatic push_word(input logic [W-1:0] b, input bit check_drop);
    logic [W-1:0] got = '0;
    int rises = 0, lat = 0, width = 0, ovr0;
    logic prev_clk = 1'b0;
    ovr0 = ovr_seen;
    din = b; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    while (dr_n) begin
      if (dclk_out && !prev_clk) begin
        if (rises < W) got[rises] = data;
        rises++;
      end
      prev_clk = dclk_out;
      if (check_drop && lat == 3 * B) begin
        din = ~b; vld = 1'b1;
      end
      if (check_drop && lat == 3 * B + 1) vld = 1'b0;
      lat++;
      @(negedge clk);
      if (lat > 20 * B) break;
    end
    chk(got == b, "R2 byte", int'(got), int'(b));
    chk(rises == W, "R2 rises", rises, W);
    chk(lat == exp_latency(B, W), "R3 latency", lat, exp_latency(B, W));
    while (!dr_n && width < 4 * D) begin width++; @(negedge clk); end
    chk(width == D, "R3 mark width", width, D);
    chk(data == 1'b1, "R3 idle data", int'(data), 1);
    if (check_drop) chk(ovr_seen == ovr0 + 1, "R4 overrun pulse", ovr_seen - ovr0, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic host_edge(input int hp);
    dclk_in = 1'b1; repeat (hp) @(negedge clk);
    dclk_in = 1'b0; repeat (hp) @(negedge clk);
  endtask

  // Mode 1 reader: read all bits of a pending word
  task automatic pull_read(input logic [W-1:0] b, input int hp, input string req);
    logic [W-1:0] got = '0;
    for (int k = 0; k < W; k++) begin
      got[k] = data;
      if (k == 0) chk(dr_n == 1'b0, "R5 ready low", int'(dr_n), 0);
      host_edge(hp);
    end
    repeat (2) @(negedge clk);
    chk(got == b, req, int'(got), int'(b));
    chk(dr_n == 1'b1, "R6 ready released", int'(dr_n), 1);
    chk(data == 1'b1, "R6 idle data", int'(data), 1);
  endtask

  initial begin
    int falls0, ovr0;
    logic [W-1:0] a, b;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(dr_n == 1'b1 && data == 1'b1 && dclk_out == 1'b0 && ovr == 1'b0,
        "R10 reset", {dr_n, data, dclk_out, ovr}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dclk_oe == 1'b1, "R1 mode0 drives dclk", int'(dclk_oe), 1);

    // Mode 0 directed and random
    push_word(8'h01, 0);
    push_word(8'h80, 0);
    push_word(8'hA5, 0);
    for (int n = 0; n < 20; n++) push_word(W'($urandom()), 0);
    // R4 drop while busy
    falls0 = dr_falls;
    push_word(8'h3C, 1);
    repeat (12 * B) @(negedge clk);
    chk(dr_falls == falls0 + 1, "R4 dropped word not sent", dr_falls - falls0, 1);

    // R9 power-down mid-word in mode 0
    falls0 = dr_falls; ovr0 = ovr_seen;
    strobe(8'h55);
    repeat (B + 3) @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk);
    chk(dr_n == 1'b1 && data == 1'b1 && dclk_out == 1'b0, "R9 pwdn outputs",
        {dr_n, data, dclk_out}, 3'b110);
    strobe(8'h0F);
    repeat (B) @(negedge clk);
    chk(dclk_out == 1'b0 && dr_n == 1'b1, "R9 strobe ignored", {dclk_out, dr_n}, 2'b01);
    pwr_down = 1'b0;
    repeat (12 * B) @(negedge clk);
    chk(dr_falls == falls0 && ovr_seen == ovr0, "R9 no mark after abandon", dr_falls - falls0, 0);

    // Mode 1
    mode_sel = 1'b1;
    @(negedge clk);
    chk(dclk_oe == 1'b0 && dclk_out == 1'b0, "R1 mode1 host clock", {dclk_oe, dclk_out}, 0);
    // R8 edges with nothing pending
    for (int k = 0; k < 3; k++) host_edge(3);
    chk(dr_n == 1'b1 && data == 1'b1, "R8 idle edges ignored", {dr_n, data}, 2'b11);
    strobe(8'hC3);
    chk(data == exp_bit(8'hC3, 0), "R5 bit0 shown", int'(data), int'(exp_bit(8'hC3, 0)));
    pull_read(8'hC3, 3, "R8 word after idle edges");
    for (int n = 0; n < 20; n++) begin
      a = W'($urandom());
      strobe(a);
      pull_read(a, 2 + int'($urandom_range(0, 3)), "R6 random word");
    end
    // R7 overwrite of a partly read word
    a = 8'h96; b = 8'h4B;
    ovr0 = ovr_seen;
    strobe(a);
    for (int k = 0; k < 3; k++) host_edge(3);
    chk(data == exp_bit(a, 3), "R6 bit3 after 3 edges", int'(data), int'(exp_bit(a, 3)));
    din = b; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk(dr_n == 1'b1, "R7 ready gap", int'(dr_n), 1);
    @(negedge clk);
    chk(dr_n == 1'b0, "R7 ready again", int'(dr_n), 0);
    chk(ovr_seen == ovr0 + 1, "R7 overrun pulse", ovr_seen - ovr0, 1);
    pull_read(b, 3, "R7 new word from bit0");

    // R9 power-down in mode 1
    strobe(8'h77);
    pwr_down = 1'b1;
    @(negedge clk);
    chk(dr_n == 1'b1 && data == 1'b1, "R9 pwdn mode1", {dr_n, data}, 2'b11);
    pwr_down = 1'b0;
    repeat (4) @(negedge clk);
    chk(dr_n == 1'b1, "R9 pending word abandoned", int'(dr_n), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule